// File: doc/BRIEF.md
# Oversampled DRAM strobe sequencer for an 8-bit CPU bus

This block sits between an 8-bit microprocessor bus and a single byte-wide DRAM module of up to 4 MB. It watches the CPU's memory-request, read, write and refresh strobes, which are all active low, through a fast oversampling clock. From them it produces the row/column-multiplexed DRAM address and the RAS, CAS and WE strobes, using a counter-based timing chain in place of an analog delay line. The CPU is never stalled. Every access has fixed timing from the request, so the module's speed grade is chosen to fit the CPU's opcode-fetch window. That window is the tightest one: it leaves about 255 ns of access time at a 250 ns CPU clock once strobe skew and data setup are allowed for.

A memory request with read or write runs a normal RAS-then-CAS access. The 22-bit DRAM address is the bank register followed by the CPU address. Writes use early-write timing: WE is low before CAS falls, so the module's shared data pins never drive. A memory request with the refresh strobe runs a CAS-before-RAS refresh, which fills the idle half of every opcode fetch and needs no refresh address. Releasing the memory request ends any cycle. A minimum precharge time is then enforced before the next cycle may start.

Top module: `dram_simm_ctrl`

## Requirements
- R1: While reset is high, and immediately after it, ras_n, cas_n and we_n are all 1.
- R2: With mreq_n, rd_n and wr_n treated as active low, a cycle starts when mreq_n is 0 together with rd_n or wr_n while rfsh_n is 1. ras_n then falls with dram_addr equal to bits [21:11] of the 22-bit value {bank, cpu_addr}.
- R3: In a normal access, dram_addr changes to bits [10:0] of {bank, cpu_addr} exactly T_ROW_HOLD (default 2) fast-clock cycles after ras_n falls. cas_n falls T_COL_SETUP (default 2) cycles after that, which is 4 cycles after ras_n by default.
- R4: In a write (wr_n = 0), we_n is already 0 in the cycle in which ras_n falls and stays 0 through the fall of cas_n. In a read, we_n stays 1 throughout.
- R5: When mreq_n and rfsh_n are both 0, a refresh runs. cas_n falls first while ras_n and we_n are 1, and ras_n falls T_CBR_DELAY (default 2) cycles later. Refresh takes precedence over rd_n.
- R6: Strobes that have fallen stay low while mreq_n is held at 0. All three strobes are 1 at the SYNC_STAGES+1-th rising edge after mreq_n returns to 1, even if the cycle ended before cas_n fell.
- R7: Between two cycles, ras_n stays 1 for at least T_PRECHARGE+1 (default 5) cycles. A request that is already pending when the precharge ends starts right after it.
- R8: mreq_n at 0 with rd_n, wr_n and rfsh_n all at 1 produces no strobe.
- R9: From an idle, precharged state, ras_n falls at exactly the SYNC_STAGES+1-th rising edge (default 3) after a read request is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| mreq_n | input | 1 | CPU memory request, active low, asynchronous |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| rfsh_n | input | 1 | CPU refresh slot indicator, active low |
| cpu_addr | input | ADDR_W (16) | CPU address |
| bank | input | BANK_W (6) | Bank register supplying the upper DRAM address bits |
| dram_addr | output | DA_W (11) | Multiplexed row/column address |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The hardest case to reach is a new request that arrives while the precharge count is still running. To reach it, the stimulus releases mreq_n for a single fast-clock cycle between two accesses. The monitor then measures how long ras_n stays high between the two cycles. A second hard case is a cycle that is released before CAS has fallen. The stimulus reaches it with a very short request hold, and checks that the strobes still return high on time and that no CAS appears late.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_CAS,
    ST_CBR_CAS,
    ST_CBR_BOTH,
    ST_PRECH
  } strobe_st_t;

  typedef struct packed {
    logic mreq;
    logic rd;
    logic wr;
    logic rfsh;
  } bus_req_t;

endpackage

// File: rtl/dram_bus_sync.sv
module dram_bus_sync #(
  parameter int STAGES = 2,
  parameter int W      = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= '0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 6,
  parameter int DA_W   = (ADDR_W + BANK_W) / 2
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [DA_W-1:0]   row,
  output logic [DA_W-1:0]   col
);

  localparam int FULL_W = ADDR_W + BANK_W;

  logic [FULL_W-1:0] full;

  assign full = {bank, cpu_addr};
  assign row  = full[2*DA_W-1:DA_W];
  assign col  = full[DA_W-1:0];

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
  import dram_ctrl_pkg::*;
#(
  parameter int DA_W        = 11,
  parameter int T_ROW_HOLD  = 2,
  parameter int T_COL_SETUP = 2,
  parameter int T_CBR_DELAY = 2,
  parameter int T_PRECHARGE = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  bus_req_t        req,
  input  logic [DA_W-1:0] row,
  input  logic [DA_W-1:0] col,
  output logic [DA_W-1:0] dram_addr,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n
);

  localparam int MAX_A = (T_ROW_HOLD > T_COL_SETUP) ? T_ROW_HOLD : T_COL_SETUP;
  localparam int MAX_B = (T_CBR_DELAY > T_PRECHARGE) ? T_CBR_DELAY : T_PRECHARGE;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_T + 1);

  strobe_st_t       st;
  logic [CNT_W-1:0] cnt;
  logic [DA_W-1:0]  col_q;
  logic             active;

  assign active = (st != ST_IDLE) && (st != ST_PRECH);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      col_q     <= '0;
      dram_addr <= '0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
    end else if (active && !req.mreq) begin
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      cnt   <= CNT_W'(T_PRECHARGE - 1);
      st    <= ST_PRECH;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req.mreq && req.rfsh) begin
            cas_n <= 1'b0;
            cnt   <= CNT_W'(T_CBR_DELAY - 1);
            st    <= ST_CBR_CAS;
          end else if (req.mreq && (req.rd || req.wr)) begin
            ras_n     <= 1'b0;
            we_n      <= !req.wr;
            dram_addr <= row;
            col_q     <= col;
            cnt       <= CNT_W'(T_ROW_HOLD - 1);
            st        <= ST_ROW;
          end
        end
        ST_ROW: begin
          if (cnt == '0) begin
            dram_addr <= col_q;
            cnt       <= CNT_W'(T_COL_SETUP - 1);
            st        <= ST_COL;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_COL: begin
          if (cnt == '0) begin
            cas_n <= 1'b0;
            st    <= ST_CAS;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CBR_CAS: begin
          if (cnt == '0) begin
            ras_n <= 1'b0;
            st    <= ST_CBR_BOTH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PRECH: begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= st;
      endcase
    end
  end

  // Observation counter for the precharge property: cycles ras_n has been high.
  localparam int HI_MAX = T_PRECHARGE + 2;
  localparam int HI_W   = $clog2(HI_MAX + 1);
  logic [HI_W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)                          hi_cnt <= HI_W'(HI_MAX);
    else if (!ras_n)                  hi_cnt <= '0;
    else if (hi_cnt != HI_W'(HI_MAX)) hi_cnt <= hi_cnt + 1'b1;
  end

  // R7
  precharge_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (hi_cnt >= HI_W'(T_PRECHARGE + 1)));

  // R6
  release_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    !req.mreq |=> (ras_n && cas_n && we_n));

  // R8
  idle_mreq_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && req.mreq && !req.rd && !req.wr && !req.rfsh) |=> (ras_n && cas_n));

  // R5
  cbr_we_high_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && ras_n) |-> we_n);

  // R4
  early_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> cas_n);

  // R3
  col_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && !ras_n) |-> $stable(dram_addr));

endmodule

// File: rtl/dram_simm_ctrl.sv
module dram_simm_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BANK_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int T_ROW_HOLD  = 2,
  parameter int T_COL_SETUP = 2,
  parameter int T_CBR_DELAY = 2,
  parameter int T_PRECHARGE = 4,
  localparam int DA_W       = (ADDR_W + BANK_W) / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              rfsh_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BANK_W-1:0] bank,
  output logic [DA_W-1:0]   dram_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n
);

  localparam int REQ_W = $bits(bus_req_t);

  bus_req_t         raw_req;
  logic [REQ_W-1:0] req_sync;
  bus_req_t         req;
  logic [DA_W-1:0]  row;
  logic [DA_W-1:0]  col;

  assign raw_req.mreq = !mreq_n;
  assign raw_req.rd   = !rd_n;
  assign raw_req.wr   = !wr_n;
  assign raw_req.rfsh = !rfsh_n;

  dram_bus_sync #(
    .STAGES (SYNC_STAGES),
    .W      (REQ_W)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_req),
    .q   (req_sync)
  );

  assign req = bus_req_t'(req_sync);

  dram_addr_split #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .DA_W   (DA_W)
  ) u_split (
    .bank     (bank),
    .cpu_addr (cpu_addr),
    .row      (row),
    .col      (col)
  );

  dram_strobe_seq #(
    .DA_W        (DA_W),
    .T_ROW_HOLD  (T_ROW_HOLD),
    .T_COL_SETUP (T_COL_SETUP),
    .T_CBR_DELAY (T_CBR_DELAY),
    .T_PRECHARGE (T_PRECHARGE)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .row       (row),
    .col       (col),
    .dram_addr (dram_addr),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (ras_n && cas_n && we_n));

  // R2
  cas_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $past(req.mreq));

endmodule

// File: tb/tb_dram_simm_ctrl.sv
`timescale 1ns/1ps
module tb_dram_simm_ctrl;

  localparam int ADDR_W = 16;
  localparam int BANK_W = 6;
  localparam int DA_W   = 11;
  localparam int SYNC   = 2;
  localparam int T_ROW  = 2;
  localparam int T_COL  = 2;
  localparam int T_CBR  = 2;
  localparam int T_PRE  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rfsh_n = 1'b1;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [BANK_W-1:0] bank = '0;
  logic [DA_W-1:0]   dram_addr;
  logic              ras_n, cas_n, we_n;

  always #2.5 clk = ~clk;

  dram_simm_ctrl dut (
    .clk (clk), .rst (rst), .mreq_n (mreq_n), .rd_n (rd_n), .wr_n (wr_n),
    .rfsh_n (rfsh_n), .cpu_addr (cpu_addr), .bank (bank),
    .dram_addr (dram_addr), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n)
  );

  typedef struct {
    bit              refresh;
    bit              wr;
    logic [DA_W-1:0] row;
    logic [DA_W-1:0] col;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: pops expected cycles at each cycle start and compares the strobe sequence.
  exp_t cur;
  bit   in_acc = 1'b0;
  bit   pr = 1'b1, pc = 1'b1;
  int   tick = 0;
  int   hi = 1000;

  always @(negedge clk) begin
    if (rst) begin
      pr = 1'b1; pc = 1'b1; hi = 1000; in_acc = 1'b0;
    end else begin
      tick++;
      if (pr && !ras_n && pc) begin
        check(hi >= T_PRE + 1, "R7", "ras_n high time before access", hi, T_PRE + 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected access strobe", 1, 0);
        end else begin
          cur = exp_q.pop_front();
          check(!cur.refresh, "R2", "access started instead of refresh", 1, 0);
          check(dram_addr == cur.row, "R2", "row address at RAS", dram_addr, cur.row);
          check(we_n == !cur.wr, "R4", "we_n at RAS fall", we_n, !cur.wr);
          in_acc = 1'b1;
        end
        tick = 0;
      end else if (pc && !cas_n && pr) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected refresh strobe", 1, 0);
        end else begin
          cur = exp_q.pop_front();
          check(cur.refresh, "R5", "refresh started instead of access", 0, 1);
          check(we_n == 1'b1, "R5", "we_n at refresh CAS", we_n, 1);
        end
        in_acc = 1'b0;
        tick = 0;
      end else if (pr && !ras_n && !pc) begin
        check(tick == T_CBR, "R5", "CAS to RAS delay in refresh", tick, T_CBR);
        hi = hi;
      end else if (pc && !cas_n && !pr) begin
        check(in_acc, "R3", "CAS fell outside an access", 0, 1);
        check(tick == T_ROW + T_COL, "R3", "RAS to CAS delay", tick, T_ROW + T_COL);
        check(dram_addr == cur.col, "R3", "column address at CAS", dram_addr, cur.col);
        check(we_n == !cur.wr, "R4", "we_n at CAS fall", we_n, !cur.wr);
      end
      if (in_acc && !ras_n && cas_n && tick == T_ROW - 1)
        check(dram_addr == cur.row, "R3", "row still on mux before switch", dram_addr, cur.row);
      if (in_acc && !ras_n && cas_n && tick == T_ROW)
        check(dram_addr == cur.col, "R3", "column on mux after switch", dram_addr, cur.col);
      if (ras_n) begin
        if (!pr) in_acc = 1'b0;
        hi++;
      end else begin
        hi = 0;
      end
      pr = ras_n;
      pc = cas_n;
    end
  end

  // Driver: applies one bus cycle and pushes the expected strobe sequence.
  task automatic run_cycle(input bit is_ref, input bit is_rd, input bit is_wr,
                           input logic [BANK_W-1:0] bk, input logic [ADDR_W-1:0] a,
                           input int hold, input int gap, input bit chk_lat);
    logic [ADDR_W+BANK_W-1:0] full;
    exp_t e;
    full = {bk, a};
    if (is_ref || is_rd || is_wr) begin
      e.refresh = is_ref;
      e.wr      = is_wr && !is_ref;
      e.row     = full[2*DA_W-1:DA_W];
      e.col     = full[DA_W-1:0];
      exp_q.push_back(e);
    end
    @(negedge clk);
    bank = bk; cpu_addr = a;
    mreq_n = 1'b0; rd_n = !is_rd; wr_n = !is_wr; rfsh_n = !is_ref;
    if (chk_lat) begin
      repeat (SYNC) @(posedge clk);
      @(negedge clk);
      check(ras_n == 1'b1, "R9", "ras_n one edge before latency", ras_n, 1);
      @(posedge clk);
      @(negedge clk);
      check(ras_n == 1'b0, "R9", "ras_n at request latency", ras_n, 0);
      repeat (hold - SYNC - 1) @(negedge clk);
    end else begin
      repeat (hold) @(negedge clk);
    end
    if (!is_ref && !is_rd && !is_wr) begin
      check(ras_n && cas_n, "R8", "strobes during bare mreq", {ras_n, cas_n}, 3);
    end else if (hold >= SYNC + 1 + T_ROW + T_COL + 1) begin
      check(!ras_n && !cas_n, "R6", "strobes held low during request", {ras_n, cas_n}, 0);
    end
    mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; rfsh_n = 1'b1;
    if (gap > SYNC) begin
      repeat (SYNC) @(posedge clk);
      @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      check(ras_n && cas_n && we_n, "R6", "strobes released",
            {ras_n, cas_n, we_n}, 7);
      repeat (gap - SYNC - 1) @(negedge clk);
    end else begin
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ras_n && cas_n && we_n, "R1", "strobes in reset", {ras_n, cas_n, we_n}, 7);
    rst = 1'b0;
    @(negedge clk);
    check(ras_n && cas_n && we_n, "R1", "strobes after reset", {ras_n, cas_n, we_n}, 7);
    repeat (5) @(negedge clk);

    // R9 and R2: read from idle, latency measured
    run_cycle(0, 1, 0, 6'h2A, 16'h1234, 20, 12, 1);
    // R4: writes and reads over several address patterns
    run_cycle(0, 0, 1, 6'h15, 16'hBEEF, 20, 12, 0);
    run_cycle(0, 1, 0, 6'h3F, 16'hFFFF, 20, 12, 0);
    run_cycle(0, 0, 1, 6'h00, 16'h0000, 20, 12, 0);
    run_cycle(0, 1, 0, 6'h01, 16'h8001, 20, 12, 0);
    // R5: refresh, and refresh with read also active
    run_cycle(1, 0, 0, 6'h07, 16'h0055, 20, 12, 0);
    run_cycle(1, 1, 0, 6'h09, 16'h4321, 20, 12, 0);
    // R8: bare memory request
    run_cycle(0, 0, 0, 6'h11, 16'h2222, 20, 12, 0);
    // R7: back-to-back with a one-cycle release
    run_cycle(0, 1, 0, 6'h22, 16'hA5A5, 20, 1, 0);
    run_cycle(0, 0, 1, 6'h33, 16'h5A5A, 20, 1, 0);
    run_cycle(1, 0, 0, 6'h04, 16'h0000, 20, 12, 0);
    // R6: cycle aborted before CAS falls
    run_cycle(0, 1, 0, 6'h0C, 16'hC0DE, 4, 12, 0);
    repeat (10) @(negedge clk);
    check(cas_n == 1'b1, "R6", "no late CAS after abort", cas_n, 1);
    run_cycle(0, 1, 0, 6'h1E, 16'h7777, 20, 12, 0);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R2", "expected cycles left unseen", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule